// File: doc/BRIEF.md
# Byte Transfer Tracker with Maskable Event Status

This block follows one byte-oriented transfer and reports what happens during it. The host loads a down-counting byte count and an up-counting host address through a small byte-wide register bus. Each pulse on the byte-done input marks one byte that has been confirmed as moved. On that pulse the count drops by one and the address rises by one in the same clock edge, so the address always names the next byte to move.

A status register collects events. Two events come from the counter itself: the count reaching zero, and the count wrapping below zero. The other five come in as pulses from neighbouring logic. Reading the status offset returns the pending bits. Writing the same offset clears every bit written as one. A separate enable register masks the status, and any pending enabled bit raises a single interrupt line without a register stage.

Top module: `xfer_track`

## Requirements
- R1: After reset the byte count, host address, status and enable all read zero and the interrupt is low.
- R2: The byte count is written and read as three byte lanes at offsets 0 (bits 7:0), 1 (bits 15:8) and 2 (bits 23:16). A write changes only the addressed lane and shows on read after the write edge.
- R3: A byte-done pulse lowers the byte count by one at the clock edge where it is sampled.
- R4: The host address is written and read as four lanes at offsets 4 (bits 7:0) to 7 (bits 31:24). It rises by one, with carry across lanes, at the same edge at which a byte-done pulse lowers the count.
- R5: In a cycle with a bus write to any counter lane (offsets 0 to 2 or 4 to 7), a byte-done pulse has no effect: neither counter steps and no counter event sets.
- R6: Status bit 2 (done) sets when a byte-done pulse takes the count from 1 to 0.
- R7: Status bit 3 (wrap) sets when a byte-done pulse arrives while the count is 0. The count becomes 0xFFFFFF and bit 2 is not set by that pulse.
- R8: Status reads at offset 8. Bit 6 is selection-done, bit 5 selected-in, bit 4 selection-in-progress, bit 3 wrap, bit 2 done, bit 1 PIO-ready, bit 0 DMA-done, and bit 7 reads 0. A pulse on event input bit 6, 5, 4, 1 or 0 sets the status bit of the same index. Event input bits 3 and 2 have no effect.
- R9: A write to offset 8 clears each status bit whose write-data bit is 1 and leaves bits written 0 unchanged.
- R10: When a clear and a setting event hit the same status bit in the same cycle, the bit stays set.
- R11: The enable register reads and writes at offset 9, bit n enabling status bit n. The interrupt is high exactly while some status bit and its enable bit are both 1. It follows a status or enable change with no extra cycle.
- R12: Offsets 3 and 10 to 15 read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 4 | Register offset for read and write |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the offset on bus_addr_i, combinational |
| byte_done_i | input | 1 | One pulse per byte confirmed as transferred |
| evt_i | input | 7 | Event pulses for status bits, indexed as the status bits |
| irq_o | output | 1 | Interrupt, high while an enabled status bit is pending |

## Verification
Every register write, byte-done pulse and event pulse takes effect at the single rising edge where it is sampled. Read data and the interrupt are combinational from those registers, so every result is due right after that edge with no further cycle of delay. The bench drives a stimulus at a falling edge and drops it one time unit after the next rising edge. It then moves the read offset to the register under test and samples read data and interrupt before the following falling edge, so each result is seen exactly one edge after its cause and never with a stale or doubled step.

// File: rtl/xt_pkg.sv
package xt_pkg;

   // status bit positions; software decodes these, so they are fixed
   localparam int STAT_N    = 7;
   localparam int ST_DMA    = 0;
   localparam int ST_PIO    = 1;
   localparam int ST_DONE   = 2;
   localparam int ST_WRAP   = 3;
   localparam int ST_SELP   = 4;
   localparam int ST_SELIN  = 5;
   localparam int ST_SELD   = 6;

   // status bits that only the counter can set
   localparam logic [STAT_N-1:0] INT_ONLY = (STAT_N'(1) << ST_DONE) | (STAT_N'(1) << ST_WRAP);

   // register offsets
   localparam int RA_CNT  = 0;
   localparam int RA_ADR  = 4;
   localparam int RA_STAT = 8;
   localparam int RA_EN   = 9;

endpackage

// File: rtl/xt_lane_ctr.sv
module xt_lane_ctr #(
   parameter int W     = 24,
   parameter int LW    = 8,
   parameter bit UP    = 1'b0,
   localparam int LANES = W / LW
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [LANES-1:0] ld_i,
   input  logic [LW-1:0]    ld_data_i,
   input  logic             step_i,
   output logic [W-1:0]     val_o
);

   logic [W-1:0] val_q;
   logic [W-1:0] stepped;
   logic [W-1:0] nxt;

   if (W % LW != 0) begin : g_bad_width
      $error("xt_lane_ctr: W must be a multiple of LW");
   end

   if (UP) begin : g_up
      assign stepped = val_q + W'(1);
   end else begin : g_down
      assign stepped = val_q - W'(1);
   end

   always_comb begin
      nxt = val_q;
      if (step_i) begin
         nxt = stepped;
      end
      for (int l = 0; l < LANES; l++) begin
         if (ld_i[l]) begin
            nxt[l*LW +: LW] = ld_data_i;
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         val_q <= '0;
      end else begin
         val_q <= nxt;
      end
   end

   assign val_o = val_q;

endmodule

// File: rtl/xt_stat_bank.sv
module xt_stat_bank #(
   parameter int N = 7
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [N-1:0] set_i,
   input  logic         clr_wr_i,
   input  logic         en_wr_i,
   input  logic [N-1:0] wdata_i,
   output logic [N-1:0] stat_o,
   output logic [N-1:0] en_o,
   output logic         irq_o
);

   if (N < 1) begin : g_bad_n
      $error("xt_stat_bank: N must be at least 1");
   end

   for (genvar b = 0; b < N; b++) begin : g_bit
      logic pend_q;
      logic mask_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            pend_q <= 1'b0;
         end else if (set_i[b]) begin
            pend_q <= 1'b1;
         end else if (clr_wr_i && wdata_i[b]) begin
            pend_q <= 1'b0;
         end
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            mask_q <= 1'b0;
         end else if (en_wr_i) begin
            mask_q <= wdata_i[b];
         end
      end

      assign stat_o[b] = pend_q;
      assign en_o[b]   = mask_q;
   end

   assign irq_o = |(stat_o & en_o);

endmodule

// File: rtl/xfer_track.sv
module xfer_track
   import xt_pkg::*;
#(
   parameter int CNT_W = 24,
   parameter int ADR_W = 32,
   parameter int BUS_W = 8,
   parameter int AW    = 4,
   localparam int CNT_LANES = CNT_W / BUS_W,
   localparam int ADR_LANES = ADR_W / BUS_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [AW-1:0]     bus_addr_i,
   input  logic              bus_wr_i,
   input  logic [BUS_W-1:0]  bus_wdata_i,
   output logic [BUS_W-1:0]  bus_rdata_o,
   input  logic              byte_done_i,
   input  logic [STAT_N-1:0] evt_i,
   output logic              irq_o
);

   if (CNT_W % BUS_W != 0 || ADR_W % BUS_W != 0) begin : g_bad_lanes
      $error("xfer_track: counter widths must be whole bus lanes");
   end
   if (RA_CNT + CNT_LANES > RA_ADR || RA_ADR + ADR_LANES > RA_STAT) begin : g_bad_map
      $error("xfer_track: counter lanes overlap the register map");
   end
   if (RA_EN >= (1 << AW)) begin : g_bad_aw
      $error("xfer_track: AW too small for the register map");
   end
   if (BUS_W < STAT_N) begin : g_bad_bus
      $error("xfer_track: bus narrower than status");
   end

   logic [CNT_LANES-1:0] cnt_ld;
   logic [ADR_LANES-1:0] adr_ld;
   logic                 host_ctr_wr;
   logic                 step;
   logic [CNT_W-1:0]     cnt_q;
   logic [ADR_W-1:0]     adr_q;
   logic                 done_evt;
   logic                 wrap_evt;
   logic [STAT_N-1:0]    set_vec;
   logic [STAT_N-1:0]    stat_q;
   logic [STAT_N-1:0]    en_q;
   logic                 stat_wr;
   logic                 en_wr;

   for (genvar l = 0; l < CNT_LANES; l++) begin : g_cnt_dec
      assign cnt_ld[l] = bus_wr_i && (bus_addr_i == AW'(RA_CNT + l));
   end
   for (genvar l = 0; l < ADR_LANES; l++) begin : g_adr_dec
      assign adr_ld[l] = bus_wr_i && (bus_addr_i == AW'(RA_ADR + l));
   end

   assign stat_wr     = bus_wr_i && (bus_addr_i == AW'(RA_STAT));
   assign en_wr       = bus_wr_i && (bus_addr_i == AW'(RA_EN));
   assign host_ctr_wr = (|cnt_ld) || (|adr_ld);
   assign step        = byte_done_i && !host_ctr_wr;

   xt_lane_ctr #(
      .W  (CNT_W),
      .LW (BUS_W),
      .UP (1'b0)
   ) u_count (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ld_i      (cnt_ld),
      .ld_data_i (bus_wdata_i),
      .step_i    (step),
      .val_o     (cnt_q)
   );

   xt_lane_ctr #(
      .W  (ADR_W),
      .LW (BUS_W),
      .UP (1'b1)
   ) u_haddr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ld_i      (adr_ld),
      .ld_data_i (bus_wdata_i),
      .step_i    (step),
      .val_o     (adr_q)
   );

   assign done_evt = step && (cnt_q == CNT_W'(1));
   assign wrap_evt = step && (cnt_q == '0);

   always_comb begin
      set_vec          = evt_i & ~INT_ONLY;
      set_vec[ST_DONE] = done_evt;
      set_vec[ST_WRAP] = wrap_evt;
   end

   xt_stat_bank #(
      .N (STAT_N)
   ) u_stat (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .set_i    (set_vec),
      .clr_wr_i (stat_wr),
      .en_wr_i  (en_wr),
      .wdata_i  (bus_wdata_i[STAT_N-1:0]),
      .stat_o   (stat_q),
      .en_o     (en_q),
      .irq_o    (irq_o)
   );

   always_comb begin
      bus_rdata_o = '0;
      for (int l = 0; l < CNT_LANES; l++) begin
         if (bus_addr_i == AW'(RA_CNT + l)) begin
            bus_rdata_o = cnt_q[l*BUS_W +: BUS_W];
         end
      end
      for (int l = 0; l < ADR_LANES; l++) begin
         if (bus_addr_i == AW'(RA_ADR + l)) begin
            bus_rdata_o = adr_q[l*BUS_W +: BUS_W];
         end
      end
      if (bus_addr_i == AW'(RA_STAT)) begin
         bus_rdata_o = BUS_W'(stat_q);
      end
      if (bus_addr_i == AW'(RA_EN)) begin
         bus_rdata_o = BUS_W'(en_q);
      end
   end

endmodule

// File: rtl/xt_chk.sv
module xt_chk
   import xt_pkg::*;
#(
   parameter int CNT_W = 24,
   parameter int ADR_W = 32,
   parameter int BUS_W = 8,
   parameter int AW    = 4
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic [AW-1:0]     bus_addr_i,
   input logic              bus_wr_i,
   input logic [BUS_W-1:0]  bus_wdata_i,
   input logic              byte_done_i,
   input logic [STAT_N-1:0] evt_i,
   input logic              irq_o,
   input logic [CNT_W-1:0]  cnt_i,
   input logic [ADR_W-1:0]  adr_i,
   input logic [STAT_N-1:0] stat_i,
   input logic [STAT_N-1:0] en_i
);

   localparam int CL = CNT_W / BUS_W;
   localparam int AL = ADR_W / BUS_W;

   logic ctr_wr;
   logic live_step;
   assign ctr_wr = bus_wr_i &&
                   ((int'(bus_addr_i) >= RA_CNT && int'(bus_addr_i) < RA_CNT + CL) ||
                    (int'(bus_addr_i) >= RA_ADR && int'(bus_addr_i) < RA_ADR + AL));
   assign live_step = byte_done_i && !ctr_wr;

   assert_count_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      live_step |=> (cnt_i == CNT_W'($past(cnt_i) - 1'b1)));

   assert_addr_lockstep_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      live_step |=> (adr_i == ADR_W'($past(adr_i) + 1'b1)));

   assert_write_blocks_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (byte_done_i && ctr_wr && !(bus_addr_i >= AW'(RA_ADR))) |=> $stable(adr_i));

   assert_idle_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!byte_done_i && !bus_wr_i) |=> ($stable(cnt_i) && $stable(adr_i)));

   assert_wrap_sets_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (live_step && cnt_i == '0) |=> stat_i[ST_WRAP]);

   assert_done_sets_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (live_step && cnt_i == CNT_W'(1)) |=> stat_i[ST_DONE]);

   assert_clear_all_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_wr_i && bus_addr_i == AW'(RA_STAT) && bus_wdata_i[STAT_N-1:0] == '1 &&
       evt_i == '0 && !byte_done_i) |=> (stat_i == '0));

   assert_set_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_i[ST_DMA]) |=> stat_i[ST_DMA]);

   assert_irq_masked_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i == '0) |-> !irq_o);

   assert_irq_source_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> (stat_i != '0 && en_i != '0));

endmodule

bind xfer_track xt_chk #(
   .CNT_W (CNT_W),
   .ADR_W (ADR_W),
   .BUS_W (BUS_W),
   .AW    (AW)
) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .bus_addr_i  (bus_addr_i),
   .bus_wr_i    (bus_wr_i),
   .bus_wdata_i (bus_wdata_i),
   .byte_done_i (byte_done_i),
   .evt_i       (evt_i),
   .irq_o       (irq_o),
   .cnt_i       (cnt_q),
   .adr_i       (adr_q),
   .stat_i      (stat_q),
   .en_i        (en_q)
);

// File: tb/test_xfer_track.sv
module test_xfer_track;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] addr = '0;
   logic       wr = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       bdone = 1'b0;
   logic [6:0] evt = '0;
   logic       irq;

   int n_checks = 0;
   int n_errors = 0;
   bit done_flag = 1'b0;

   always #5 clk = ~clk;

   xfer_track i_xfer_track (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .bus_addr_i  (addr),
      .bus_wr_i    (wr),
      .bus_wdata_i (wdata),
      .bus_rdata_o (rdata),
      .byte_done_i (bdone),
      .evt_i       (evt),
      .irq_o       (irq)
   );

   typedef struct packed {
      logic [3:0] req;
      logic       wr;
      logic [3:0] a;
      logic [7:0] d;
      logic       bs;
      logic [6:0] ev;
      logic [3:0] ra;
      logic [7:0] exp;
      logic       irq;
   } vec_t;

   localparam int NV = 33;
   localparam vec_t TBL [NV] = '{
      '{4'd2,  1'b1, 4'h0, 8'h03, 1'b0, 7'h00, 4'h0, 8'h03, 1'b0}, // R2 low lane
      '{4'd4,  1'b1, 4'h7, 8'hAB, 1'b0, 7'h00, 4'h7, 8'hAB, 1'b0}, // R4 top lane
      '{4'd4,  1'b1, 4'h4, 8'hFC, 1'b0, 7'h00, 4'h4, 8'hFC, 1'b0}, // R4
      '{4'd3,  1'b0, 4'h0, 8'h00, 1'b1, 7'h00, 4'h0, 8'h02, 1'b0}, // R3
      '{4'd4,  1'b0, 4'h0, 8'h00, 1'b0, 7'h00, 4'h4, 8'hFD, 1'b0}, // R4 lockstep
      '{4'd3,  1'b0, 4'h0, 8'h00, 1'b1, 7'h00, 4'h0, 8'h01, 1'b0}, // R3
      '{4'd6,  1'b0, 4'h0, 8'h00, 1'b1, 7'h00, 4'h0, 8'h00, 1'b0}, // R6 reach zero
      '{4'd6,  1'b0, 4'h0, 8'h00, 1'b0, 7'h00, 4'h8, 8'h04, 1'b0}, // R6 done bit
      '{4'd4,  1'b0, 4'h0, 8'h00, 1'b0, 7'h00, 4'h4, 8'hFF, 1'b0}, // R4
      '{4'd11, 1'b1, 4'h9, 8'h04, 1'b0, 7'h00, 4'h9, 8'h04, 1'b1}, // R11 enable
      '{4'd7,  1'b0, 4'h0, 8'h00, 1'b1, 7'h00, 4'h0, 8'hFF, 1'b1}, // R7 wrap
      '{4'd7,  1'b0, 4'h0, 8'h00, 1'b0, 7'h00, 4'h2, 8'hFF, 1'b1}, // R7
      '{4'd7,  1'b0, 4'h0, 8'h00, 1'b0, 7'h00, 4'h8, 8'h0C, 1'b1}, // R7 wrap bit
      '{4'd4,  1'b0, 4'h0, 8'h00, 1'b0, 7'h00, 4'h4, 8'h00, 1'b1}, // R4 carry
      '{4'd4,  1'b0, 4'h0, 8'h00, 1'b0, 7'h00, 4'h5, 8'h01, 1'b1}, // R4 carry
      '{4'd9,  1'b1, 4'h8, 8'h04, 1'b0, 7'h00, 4'h8, 8'h08, 1'b0}, // R9 partial
      '{4'd8,  1'b0, 4'h0, 8'h00, 1'b0, 7'h7F, 4'h8, 8'h7B, 1'b0}, // R8 events
      '{4'd10, 1'b1, 4'h8, 8'h01, 1'b0, 7'h01, 4'h8, 8'h7B, 1'b0}, // R10
      '{4'd9,  1'b1, 4'h8, 8'h7F, 1'b0, 7'h00, 4'h8, 8'h00, 1'b0}, // R9 all
      '{4'd5,  1'b1, 4'h0, 8'h05, 1'b1, 7'h00, 4'h0, 8'h05, 1'b0}, // R5
      '{4'd5,  1'b0, 4'h0, 8'h00, 1'b0, 7'h00, 4'h4, 8'h00, 1'b0}, // R5 addr held
      '{4'd5,  1'b0, 4'h0, 8'h00, 1'b0, 7'h00, 4'h8, 8'h00, 1'b0}, // R5 no event
      '{4'd12, 1'b1, 4'hA, 8'h55, 1'b0, 7'h00, 4'hA, 8'h00, 1'b0}, // R12
      '{4'd11, 1'b1, 4'h9, 8'h08, 1'b0, 7'h00, 4'h9, 8'h08, 1'b0}, // R11
      '{4'd2,  1'b1, 4'h0, 8'h01, 1'b0, 7'h00, 4'h0, 8'h01, 1'b0}, // R2
      '{4'd2,  1'b1, 4'h1, 8'h00, 1'b0, 7'h00, 4'h1, 8'h00, 1'b0}, // R2
      '{4'd2,  1'b1, 4'h2, 8'h00, 1'b0, 7'h00, 4'h2, 8'h00, 1'b0}, // R2
      '{4'd11, 1'b0, 4'h0, 8'h00, 1'b1, 7'h00, 4'h8, 8'h04, 1'b0}, // R11 masked
      '{4'd11, 1'b0, 4'h0, 8'h00, 1'b1, 7'h00, 4'h8, 8'h0C, 1'b1}, // R11 enabled
      '{4'd4,  1'b0, 4'h0, 8'h00, 1'b0, 7'h00, 4'h4, 8'h02, 1'b1}, // R4
      '{4'd9,  1'b1, 4'h8, 8'h7F, 1'b0, 7'h00, 4'h8, 8'h00, 1'b0}, // R9
      '{4'd8,  1'b0, 4'h0, 8'h00, 1'b0, 7'h0C, 4'h8, 8'h00, 1'b0}, // R8 ignored bits
      '{4'd4,  1'b0, 4'h0, 8'h00, 1'b0, 7'h00, 4'h7, 8'hAB, 1'b0}  // R4
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic read_chk(input string req, input logic [3:0] ra, input logic [7:0] exp);
      addr = ra;
      #1;
      check(req, rdata, exp);
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   endtask

   initial begin
      #2000000;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
   end

   initial begin
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state of every register
      read_chk("R1", 4'h0, 8'h00);
      read_chk("R1", 4'h2, 8'h00);
      read_chk("R1", 4'h4, 8'h00);
      read_chk("R1", 4'h7, 8'h00);
      read_chk("R1", 4'h8, 8'h00);
      read_chk("R1", 4'h9, 8'h00);
      check("R1", {7'd0, irq}, 8'h00);

      foreach (TBL[i]) begin
         @(negedge clk);
         wr    = TBL[i].wr;
         addr  = TBL[i].a;
         wdata = TBL[i].d;
         bdone = TBL[i].bs;
         evt   = TBL[i].ev;
         @(posedge clk);
         #1;
         wr    = 1'b0;
         bdone = 1'b0;
         evt   = '0;
         addr  = TBL[i].ra;
         #1;
         check($sformatf("R%0d vec %0d rdata", TBL[i].req, i), rdata, TBL[i].exp);
         check($sformatf("R%0d vec %0d irq", TBL[i].req, i), {7'd0, irq}, {7'd0, TBL[i].irq});
      end

      // R12: offset 3 is unmapped
      @(negedge clk);
      wr = 1'b1; addr = 4'h3; wdata = 8'h5A;
      @(posedge clk);
      #1;
      wr = 1'b0;
      read_chk("R12", 4'h3, 8'h00);
      read_chk("R12", 4'h0, 8'hFF);

      // R1: asynchronous reset mid-run clears everything
      @(negedge clk);
      wr = 1'b1; addr = 4'h9; wdata = 8'h7F;
      @(posedge clk);
      #1;
      wr = 1'b0;
      rst_n = 1'b0;
      #1;
      read_chk("R1", 4'h0, 8'h00);
      read_chk("R1", 4'h5, 8'h00);
      read_chk("R1", 4'h8, 8'h00);
      read_chk("R1", 4'h9, 8'h00);
      check("R1", {7'd0, irq}, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      finish_run();
   end

endmodule